// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block gathers interrupt requests from a row of peripheral sources and from five fixed system sources. It turns them into a single offered interrupt for the processor core. Each peripheral source has a small control word, made of a 3-bit level and a request bit. The control word is written and read through a simple select/write port. A one-cycle event pulse on a source's event input sets its request bit. The bit then stays set until that interrupt is acknowledged or software clears it.

A two-state machine drives the offer. In `ARB_IDLE` the machine looks at every latched request each clock. If one is eligible, the GRANT transition captures the winner's number and level and moves to `ARB_OFFER`. In `ARB_OFFER` the offer is held unchanged until the core pulses acknowledge. The RELEASE transition then clears only the winner's request bit and returns to `ARB_IDLE`.

A peripheral request is eligible only when two conditions hold: the global enable is set, and its level is strictly above the core's current priority level. System sources are always eligible. The fixed ranking, from highest to lowest, is: non-maskable, debug, watchdog, peripherals, single step, address match.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and after it is released, `take_o` is 0. Every peripheral level reads 0 and every request bit reads 0.
- R2: An event pulse on `evt_i[i]` sets that source's request bit at the next clock edge. The bit reads back as 1 through `cfg_rreq_o` even when the source's level is 0 or the source is masked.
- R3: A write (`cfg_we_i`, `cfg_sel_i`) loads `cfg_wlvl_i` and `cfg_wreq_i` into the selected control word at the next clock edge. Before that edge the readback shows the old value. Writing 0 to the request bit cancels a pending request, which is then never offered.
- R4: A peripheral request is offered only if `ien_i` is 1 and its level is strictly greater than `ipl_i`. A level of 0 is never offered.
- R5: Among eligible peripherals, the highest level wins. On a tie in level, the lowest source index wins.
- R6: The fixed ranking is non-maskable > debug > watchdog > any eligible peripheral > single step > address match. System sources ignore `ien_i` and `ipl_i`. Interrupt numbers are assigned as follows: non-maskable 0, debug 1, watchdog 2, peripheral i is 3+i, single step N+3, address match N+4. System sources report level 7.
- R7: An eligible request latched at clock edge k is offered after edge k+1, with `take_o`=1, its number and its level. The offer then stays unchanged until acknowledge, even if a higher request arrives or `ipl_i`/`ien_i` change.
- R8: Acknowledge clears only the offered source's request bit, and all other requests stay latched. If a new event on that same source arrives in the acknowledge cycle, the event wins and the bit stays set.
- R9: After acknowledge, `take_o` is 0 for at least one cycle before the next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | Peripheral event pulses |
| nmi_i | input | 1 | Non-maskable event pulse |
| dbg_i | input | 1 | Debug event pulse |
| wdt_i | input | 1 | Watchdog event pulse |
| step_i | input | 1 | Single-step event pulse |
| amatch_i | input | 1 | Address-match event pulse |
| ipl_i | input | 3 | Current processor priority level |
| ien_i | input | 1 | Global peripheral interrupt enable |
| ack_i | input | 1 | Acknowledge of the offered interrupt |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_sel_i | input | clog2(N_SRC) | Selected peripheral for write and readback |
| cfg_wlvl_i | input | 3 | Level to write |
| cfg_wreq_i | input | 1 | Request bit to write |
| cfg_rlvl_o | output | 3 | Level of selected source |
| cfg_rreq_o | output | 1 | Request bit of selected source |
| take_o | output | 1 | An interrupt is offered |
| take_num_o | output | clog2(N_SRC+5) | Offered interrupt number |
| take_lvl_o | output | 3 | Offered interrupt level |

## Verification
The table drives single sources, pairs of sources tied in level, sources with level at or below the priority level, masked peripherals next to unmaskable system sources, and every fixed source against peripheral traffic. Together these separate three kinds of fault: a wrong comparison (>= against >), a wrong tie-break direction, and a wrong ranking position. Directed sequences cover several further cases. One is a level-0 source whose request must still read back. Another is a cancel write. A third is a two-source acknowledge, which shows that only the winner clears. The last two are a higher request arriving during an offer and an event that coincides with acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W   = 3;
    localparam int N_SPC   = 5;
    localparam int SPC_NMI = 0;
    localparam int SPC_DBG = 1;
    localparam int SPC_WDT = 2;
    localparam int SPC_STP = 3;
    localparam int SPC_AMT = 4;
    localparam int PER_BASE = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       evt_i,
    input  logic [N_SRC-1:0]       clr_i,
    input  logic                   cfg_we_i,
    input  logic [IDX_W-1:0]       cfg_sel_i,
    input  lvl_t                   cfg_wlvl_i,
    input  logic                   cfg_wreq_i,
    output logic [N_SRC-1:0]       req_o,
    output logic [N_SRC*LVL_W-1:0] lvl_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic hit;
        lvl_t lvl_q;
        logic req_q;

        assign hit = cfg_we_i && (cfg_sel_i == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q <= '0;
                req_q <= 1'b0;
            end else begin
                if (hit) lvl_q <= cfg_wlvl_i;
                if (evt_i[i])      req_q <= 1'b1;
                else if (clr_i[i]) req_q <= 1'b0;
                else if (hit)      req_q <= cfg_wreq_i;
            end
        end

        assign req_o[i]               = req_q;
        assign lvl_o[i*LVL_W +: LVL_W] = lvl_q;

        AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> req_q); // R2
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !req_q); // R8
        AST_WR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !evt_i[i] && !clr_i[i]) |=>
                (req_q == $past(cfg_wreq_i)) && (lvl_q == $past(cfg_wlvl_i))); // R3
    end
endmodule

// File: rtl/irq_spc_latch.sv
module irq_spc_latch
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SPC-1:0] raw_i,
    input  logic [N_SPC-1:0] clr_i,
    output logic [N_SPC-1:0] pend_o
);
    for (genvar s = 0; s < N_SPC; s++) begin : g_spc
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_o[s] <= 1'b0;
            else if (raw_i[s]) pend_o[s] <= 1'b1;
            else if (clr_i[s]) pend_o[s] <= 1'b0;
        end

        AST_SPC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            raw_i[s] |=> pend_o[s]); // R6
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int NUM_W = 4
) (
    input  logic [N_SRC-1:0]       per_req_i,
    input  logic [N_SRC*LVL_W-1:0] per_lvl_i,
    input  logic [N_SPC-1:0]       spc_i,
    input  lvl_t                   ipl_i,
    input  logic                   ien_i,
    output logic                   hit_o,
    output logic [NUM_W-1:0]       num_o,
    output lvl_t                   lvl_o
);
    localparam lvl_t LVL_TOP = '1;

    logic             best_hit;
    logic [NUM_W-1:0] best_num;
    lvl_t             best_lvl;
    lvl_t             lv;

    always_comb begin
        best_hit = 1'b0;
        best_num = '0;
        best_lvl = '0;
        lv       = '0;
        for (int i = 0; i < N_SRC; i++) begin
            lv = per_lvl_i[i*LVL_W +: LVL_W];
            if (ien_i && per_req_i[i] && (lv > ipl_i) && (!best_hit || lv > best_lvl)) begin
                best_hit = 1'b1;
                best_num = NUM_W'(PER_BASE + i);
                best_lvl = lv;
            end
        end
    end

    always_comb begin
        hit_o = 1'b1;
        num_o = '0;
        lvl_o = LVL_TOP;
        if (spc_i[SPC_NMI])      num_o = NUM_W'(0);
        else if (spc_i[SPC_DBG]) num_o = NUM_W'(1);
        else if (spc_i[SPC_WDT]) num_o = NUM_W'(2);
        else if (best_hit) begin
            num_o = best_num;
            lvl_o = best_lvl;
        end
        else if (spc_i[SPC_STP]) num_o = NUM_W'(N_SRC + 3);
        else if (spc_i[SPC_AMT]) num_o = NUM_W'(N_SRC + 4);
        else begin
            hit_o = 1'b0;
            lvl_o = '0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int NUM_W = $clog2(N_SRC + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             nmi_i,
    input  logic             dbg_i,
    input  logic             wdt_i,
    input  logic             step_i,
    input  logic             amatch_i,
    input  logic [2:0]       ipl_i,
    input  logic             ien_i,
    input  logic             ack_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_sel_i,
    input  logic [2:0]       cfg_wlvl_i,
    input  logic             cfg_wreq_i,
    output logic [2:0]       cfg_rlvl_o,
    output logic             cfg_rreq_o,
    output logic             take_o,
    output logic [NUM_W-1:0] take_num_o,
    output logic [2:0]       take_lvl_o
);
    arb_state_e st_q, st_d;
    logic [NUM_W-1:0]       win_num_q;
    lvl_t                   win_lvl_q;
    logic [N_SRC-1:0]       per_req, per_clr;
    logic [N_SRC*LVL_W-1:0] per_lvl;
    logic [N_SPC-1:0]       spc_raw, spc_pend, spc_clr;
    logic                   pick_hit, done;
    logic [NUM_W-1:0]       pick_num;
    lvl_t                   pick_lvl;

    assign spc_raw = {amatch_i, step_i, wdt_i, dbg_i, nmi_i};
    assign done    = (st_q == ARB_OFFER) && ack_i;

    for (genvar i = 0; i < N_SRC; i++) begin : g_clr
        assign per_clr[i] = done && (win_num_q == NUM_W'(PER_BASE + i));
    end
    assign spc_clr[SPC_NMI] = done && (win_num_q == NUM_W'(0));
    assign spc_clr[SPC_DBG] = done && (win_num_q == NUM_W'(1));
    assign spc_clr[SPC_WDT] = done && (win_num_q == NUM_W'(2));
    assign spc_clr[SPC_STP] = done && (win_num_q == NUM_W'(N_SRC + 3));
    assign spc_clr[SPC_AMT] = done && (win_num_q == NUM_W'(N_SRC + 4));

    irq_src_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(per_clr),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wlvl_i(cfg_wlvl_i),
        .cfg_wreq_i(cfg_wreq_i), .req_o(per_req), .lvl_o(per_lvl)
    );

    irq_spc_latch u_spc (
        .clk(clk), .rst_n(rst_n), .raw_i(spc_raw), .clr_i(spc_clr), .pend_o(spc_pend)
    );

    irq_pick #(.N_SRC(N_SRC), .NUM_W(NUM_W)) u_pick (
        .per_req_i(per_req), .per_lvl_i(per_lvl), .spc_i(spc_pend),
        .ipl_i(ipl_i), .ien_i(ien_i),
        .hit_o(pick_hit), .num_o(pick_num), .lvl_o(pick_lvl)
    );

    always_comb begin
        cfg_rlvl_o = '0;
        cfg_rreq_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cfg_sel_i == IDX_W'(i)) begin
                cfg_rlvl_o = per_lvl[i*LVL_W +: LVL_W];
                cfg_rreq_o = per_req[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE:  if (pick_hit) st_d = ARB_OFFER;
            ARB_OFFER: if (ack_i)    st_d = ARB_IDLE;
            default:                 st_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ARB_IDLE;
            win_num_q <= '0;
            win_lvl_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ARB_IDLE && pick_hit) begin
                win_num_q <= pick_num;
                win_lvl_q <= pick_lvl;
            end
        end
    end

    always_comb begin
        take_o     = (st_q == ARB_OFFER);
        take_num_o = win_num_q;
        take_lvl_o = win_lvl_q;
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !ack_i) |=> take_o && $stable(take_num_o) && $stable(take_lvl_o)); // R7
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i) |=> !take_o); // R9
    AST_PER_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_o) && take_num_o >= NUM_W'(PER_BASE) && take_num_o < NUM_W'(PER_BASE + N_SRC))
            |-> (take_lvl_o > $past(ipl_i)) && $past(ien_i)); // R4
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_o) && $past(spc_pend[SPC_NMI])) |-> take_num_o == NUM_W'(0)); // R6
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
    localparam int N = 8;
    localparam logic [2:0] LV [N] = '{3'd2, 3'd5, 3'd5, 3'd0, 3'd7, 3'd1, 3'd3, 3'd4};
    // {ipl, ien, evt[7:0], spc{amatch,step,wdt,dbg,nmi}, exp_take, exp_num, exp_lvl}
    localparam int NV = 15;
    localparam logic [24:0] VEC [NV] = '{
        {3'd0, 1'b1, 8'h01, 5'h00, 1'b1, 4'd3,  3'd2},  // R4 single
        {3'd0, 1'b1, 8'h06, 5'h00, 1'b1, 4'd4,  3'd5},  // R5 tie
        {3'd0, 1'b1, 8'h08, 5'h00, 1'b0, 4'd0,  3'd0},  // R4 level 0
        {3'd4, 1'b1, 8'h81, 5'h00, 1'b0, 4'd0,  3'd0},  // R4 equal ipl
        {3'd4, 1'b1, 8'h82, 5'h00, 1'b1, 4'd4,  3'd5},  // R5 higher
        {3'd0, 1'b0, 8'h10, 5'h00, 1'b0, 4'd0,  3'd0},  // R4 masked
        {3'd0, 1'b0, 8'h10, 5'h08, 1'b1, 4'd11, 3'd7},  // R6 step ignores ien
        {3'd7, 1'b1, 8'h10, 5'h00, 1'b0, 4'd0,  3'd0},  // R4 ipl 7
        {3'd0, 1'b1, 8'hFF, 5'h1F, 1'b1, 4'd0,  3'd7},  // R6 nmi top
        {3'd0, 1'b1, 8'h10, 5'h06, 1'b1, 4'd1,  3'd7},  // R6 dbg
        {3'd0, 1'b1, 8'h10, 5'h04, 1'b1, 4'd2,  3'd7},  // R6 wdt over per
        {3'd0, 1'b1, 8'h10, 5'h18, 1'b1, 4'd7,  3'd7},  // R6 per over step
        {3'd0, 1'b1, 8'h00, 5'h10, 1'b1, 4'd12, 3'd7},  // R6 amatch
        {3'd0, 1'b1, 8'hF0, 5'h00, 1'b1, 4'd7,  3'd7},  // R5 level 7
        {3'd7, 1'b0, 8'h00, 5'h18, 1'b1, 4'd11, 3'd7}   // R6 step over amatch
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic nmi = 0, dbg = 0, wdt = 0, stp = 0, amt = 0;
    logic [2:0] ipl = '0;
    logic ien = 1'b0, ack = 1'b0;
    logic we = 1'b0, wreq = 1'b0;
    logic [2:0] sel = '0, wlvl = '0;
    logic [2:0] rlvl, tlvl;
    logic rreq, take;
    logic [3:0] tnum;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    irq_arbiter #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .nmi_i(nmi), .dbg_i(dbg),
        .wdt_i(wdt), .step_i(stp), .amatch_i(amt), .ipl_i(ipl), .ien_i(ien),
        .ack_i(ack), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wlvl_i(wlvl),
        .cfg_wreq_i(wreq), .cfg_rlvl_o(rlvl), .cfg_rreq_o(rreq),
        .take_o(take), .take_num_o(tnum), .take_lvl_o(tlvl)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [2:0] l, input logic r);
        @(negedge clk);
        we = 1'b1; sel = idx[2:0]; wlvl = l; wreq = r;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] e, input logic [4:0] s);
        @(negedge clk);
        evt = e; {amt, stp, wdt, dbg, nmi} = s;
        @(negedge clk);
        evt = '0; {amt, stp, wdt, dbg, nmi} = '0;
        @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        ipl = '0; ien = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            ack = take;
        end
        ack = 1'b0;
        for (int i = 0; i < N; i++) wr(i, LV[i], 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 take in reset", int'(take), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 take after reset", int'(take), 0);
        for (int i = 0; i < N; i++) begin
            sel = i[2:0];
            #1;
            check("R1 level reset", int'(rlvl), 0);
            check("R1 req reset", int'(rreq), 0);
        end
        for (int i = 0; i < N; i++) wr(i, LV[i], 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ipl = VEC[v][24:22]; ien = VEC[v][21];
            pulse(VEC[v][20:13], VEC[v][12:8]);
            check($sformatf("R7 row %0d take", v), int'(take), int'(VEC[v][7]));
            if (VEC[v][7]) begin
                check($sformatf("R5/R6 row %0d num", v), int'(tnum), int'(VEC[v][6:3]));
                check($sformatf("R6 row %0d lvl", v), int'(tlvl), int'(VEC[v][2:0]));
            end
            drain();
        end

        // R2: level-0 source latches and reads back, never offered
        pulse(8'h08, 5'h00);
        sel = 3'd3; #1;
        check("R2 req readable at level 0", int'(rreq), 1);
        check("R2 level-0 not offered", int'(take), 0);
        wr(3, 3'd0, 1'b0);

        // R3: write timing and cancel
        @(negedge clk);
        we = 1'b1; sel = 3'd5; wlvl = 3'd6; wreq = 1'b0; #1;
        check("R3 old level before edge", int'(rlvl), 1);
        @(negedge clk);
        we = 1'b0;
        check("R3 new level after edge", int'(rlvl), 6);
        wr(5, 3'd1, 1'b0);
        ien = 1'b0;
        pulse(8'h01, 5'h00);
        wr(0, 3'd2, 1'b0);
        sel = 3'd0; #1;
        check("R3 cancel clears req", int'(rreq), 0);
        ien = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 cancelled not offered", int'(take), 0);

        // R8/R9: acknowledge clears only the winner
        pulse(8'h06, 5'h00);
        check("R8 first num", int'(tnum), 4);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R9 gap after ack", int'(take), 0);
        sel = 3'd1; #1;
        check("R8 winner cleared", int'(rreq), 0);
        sel = 3'd2; #1;
        check("R8 other kept", int'(rreq), 1);
        @(negedge clk);
        check("R8 next offer take", int'(take), 1);
        check("R8 next offer num", int'(tnum), 5);
        drain();

        // R7: offer held while a higher request arrives
        pulse(8'h01, 5'h00);
        check("R7 offer num", int'(tnum), 3);
        ipl = 3'd7;
        pulse(8'h00, 5'h01);
        check("R7 held take", int'(take), 1);
        check("R7 held num", int'(tnum), 3);
        check("R7 held lvl", int'(tlvl), 2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check("R6 nmi after release", int'(tnum), 0);
        check("R6 nmi level", int'(tlvl), 7);
        drain();

        // R8: event in acknowledge cycle wins
        pulse(8'h01, 5'h00);
        ack = 1'b1; evt = 8'h01;
        @(negedge clk);
        ack = 1'b0; evt = '0;
        sel = 3'd0; #1;
        check("R8 event beats ack clear", int'(rreq), 1);
        @(negedge clk);
        check("R8 re-offer num", int'(tnum), 3);
        drain();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule